// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-event flags of two timer/counters and turns each pending flag into an interrupt request. Each timer event arrives as a single-cycle pulse: counter 1 wrap, counter 1 compare A and compare B, counter 1 capture, and counter 0 wrap. Counter 1 also supplies a pulse when, in PWM mode, it reverses direction at zero. A flag stays set until software writes a one to its bit in the byte-wide flag register, or until the vector dispatch sends the acknowledge pulse for that source.

A request for a source goes high when three things are high together: the global interrupt enable, that source's enable bit, and its flag. The request is combinational from the registered flag, so it adds no cycle beyond the flag register. Choosing between pending requests is done outside this block.

Top module: `timer_irq_flags`

## Requirements
- R1: While reset is asserted, and after it is released, every flag is 0, `rd_data_o` reads 0x00 and `irq_o` is all zero until an event occurs.
- R2: An event pulse sets its flag on the next clock edge. The flag is then visible in `rd_data_o` at a fixed bit: counter 1 wrap at bit 7, compare A at bit 6, compare B at bit 5, capture at bit 3, counter 0 wrap at bit 1.
- R3: Bits 4, 2 and 0 of `rd_data_o` always read 0. Writing ones to them changes no flag.
- R4: A write (`wr_en_i`=1) with a one at a flag's bit clears that flag on the next edge. A zero at that bit leaves the flag as it was.
- R5: `ack_i[k]` clears flag k on the next edge. The source index k is the same for `ack_i`, `ien_i` and `irq_o`: 0 counter 1 wrap, 1 compare A, 2 compare B, 3 capture, 4 counter 0 wrap.
- R6: `irq_o[k]` equals `gie_i & ien_i[k] & flag k` in the same cycle.
- R7: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: With `pwm_mode_i`=1, the counter 1 wrap flag is set by `t1_bottom_i` and `t1_wrap_i` is ignored.
- R9: With `pwm_mode_i`=0, the counter 1 wrap flag is set by `t1_wrap_i` and `t1_bottom_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| pwm_mode_i | input | 1 | Counter 1 runs in up/down PWM mode |
| t1_wrap_i | input | 1 | Counter 1 wrap pulse |
| t1_bottom_i | input | 1 | Counter 1 direction reversal at zero pulse |
| cmp_a_i | input | 1 | Counter 1 compare A match pulse |
| cmp_b_i | input | 1 | Counter 1 compare B match pulse |
| capt_i | input | 1 | Counter 1 value captured pulse |
| t0_wrap_i | input | 1 | Counter 0 wrap pulse |
| ack_i | input | 5 | Per-source vector acknowledge pulses |
| ien_i | input | 5 | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 8 | Write data, ones clear flags |
| rd_data_o | output | 8 | Flag register read value |
| irq_o | output | 5 | Per-source interrupt requests |

## Verification
The bench builds the block with its default parameters: five sources, a byte-wide register and a two-stage reset synchroniser. These defaults cover every flag bit position and every reserved bit, so each lane of the bit-to-source mapping is checked against a model. The bench uses two thousand random cycles with dense event, write and acknowledge activity. These cycles often put a set and a clear on the same flag in the same cycle, and often toggle the PWM mode while both counter 1 pulses are active.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 5;

  typedef enum int {
    SRC_T1_OVF = 0,
    SRC_CMP_A  = 1,
    SRC_CMP_B  = 2,
    SRC_CAPT   = 3,
    SRC_T0_OVF = 4
  } src_e;

  // Register bit that holds the flag of a source.
  function automatic int flag_pos(input int src);
    case (src)
      0:       return 7;
      1:       return 6;
      2:       return 5;
      3:       return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[flag_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tif_set_select.sv
module tif_set_select
  import tif_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic             pwm_mode_i,
  input  logic             t1_wrap_i,
  input  logic             t1_bottom_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic             capt_i,
  input  logic             t0_wrap_i,
  output logic [N_SRC-1:0] set_o
);
  always_comb begin
    set_o             = '0;
    set_o[SRC_T1_OVF] = pwm_mode_i ? t1_bottom_i : t1_wrap_i;
    set_o[SRC_CMP_A]  = cmp_a_i;
    set_o[SRC_CMP_B]  = cmp_b_i;
    set_o[SRC_CAPT]   = capt_i;
    set_o[SRC_T0_OVF] = t0_wrap_i;
  end
endmodule

// File: rtl/tif_reg_pack.sv
module tif_reg_pack
  import tif_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = REG_W
) (
  input  logic [N_SRC-1:0] flags_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [N_SRC-1:0] wclr_o,
  output logic [DW-1:0]    rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_SRC; i++) rd_data_o[flag_pos(i)] = flags_i[i];
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_wclr
    assign wclr_o[g] = wr_en_i & wr_data_i[flag_pos(g)];
  end
endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wclr_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_ce;

  // Next state: a set beats any clear in the same cycle.
  always_comb begin
    flag_ce = set_i | wclr_i | ack_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_q);
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr_i && !set_i) |=> !flag_q);
  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !wclr_i && !ack_i) |=> $stable(flag_q));
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import tif_pkg::*;
#(
  parameter int DW         = REG_W,
  parameter int N_SRC      = NUM_SRC,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_mode_i,
  input  logic             t1_wrap_i,
  input  logic             t1_bottom_i,
  input  logic             cmp_a_i,
  input  logic             cmp_b_i,
  input  logic             capt_i,
  input  logic             t0_wrap_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [N_SRC-1:0] ien_i,
  input  logic             gie_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [N_SRC-1:0] irq_o
);
  localparam logic [DW-1:0] RSV_MASK = ~live_mask();

  // Asserted asynchronously, released on a clock edge.
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  logic [N_SRC-1:0] set_v, wclr_v, flags_v;

  tif_set_select #(.N_SRC(N_SRC)) u_set (
    .pwm_mode_i (pwm_mode_i),
    .t1_wrap_i  (t1_wrap_i),
    .t1_bottom_i(t1_bottom_i),
    .cmp_a_i    (cmp_a_i),
    .cmp_b_i    (cmp_b_i),
    .capt_i     (capt_i),
    .t0_wrap_i  (t0_wrap_i),
    .set_o      (set_v)
  );

  tif_reg_pack #(.N_SRC(N_SRC), .DW(DW)) u_reg (
    .flags_i  (flags_v),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wclr_o   (wclr_v),
    .rd_data_o(rd_data_o)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    tif_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_int_n),
      .set_i (set_v[g]),
      .wclr_i(wclr_v[g]),
      .ack_i (ack_i[g]),
      .flag_o(flags_v[g])
    );
  end

  assign irq_o = gie_i ? (ien_i & flags_v) : '0;

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en_i |=> ((rd_data_o & RSV_MASK) == '0));
  assert_irq_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|irq_o) |-> gie_i);
  assert_irq_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((irq_o & ~ien_i) == '0));
  assert_pwm_ignores_wrap_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pwm_mode_i && !t1_bottom_i && t1_wrap_i) |-> !set_v[SRC_T1_OVF]);
  assert_bottom_ignored_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pwm_mode_i && t1_bottom_i && !t1_wrap_i) |-> !set_v[SRC_T1_OVF]);
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_int_n |-> (rd_data_o == '0));
endmodule

// File: tb/tb_timer_irq_flags.sv
module tb_timer_irq_flags;
  localparam int DW = 8;
  localparam int NS = 5;
  localparam int RAND_CYCLES = 2000;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n, pwm, w1, b1, ca, cb, cp, w0, gie, wr;
  logic [NS-1:0] ack, ien, irq;
  logic [DW-1:0] wd, rd;

  timer_irq_flags dut (
    .clk(clk), .rst_n(rst_n), .pwm_mode_i(pwm), .t1_wrap_i(w1), .t1_bottom_i(b1),
    .cmp_a_i(ca), .cmp_b_i(cb), .capt_i(cp), .t0_wrap_i(w0), .ack_i(ack),
    .ien_i(ien), .gie_i(gie), .wr_en_i(wr), .wr_data_i(wd),
    .rd_data_o(rd), .irq_o(irq)
  );

  int tests = 0;
  int fails = 0;
  logic [NS-1:0] model = '0;

  function automatic int bitpos(input int s);
    case (s) 0: return 7; 1: return 6; 2: return 5; 3: return 3; default: return 1; endcase
  endfunction

  function automatic logic [DW-1:0] pack(input logic [NS-1:0] f);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NS; i++) r[bitpos(i)] = f[i];
    return r;
  endfunction

  function automatic logic [NS-1:0] next_flags(input logic [NS-1:0] f);
    logic [NS-1:0] n = f;
    logic [NS-1:0] s;
    s = {w0, cp, cb, ca, (pwm ? b1 : w1)};
    for (int i = 0; i < NS; i++) begin
      if (s[i]) n[i] = 1'b1;
      else if ((wr && wd[bitpos(i)]) || ack[i]) n[i] = 1'b0;
    end
    return n;
  endfunction

  task automatic check(input string tag);
    logic [NS-1:0] ei;
    ei = gie ? (ien & model) : '0;
    tests++;
    if (rd !== pack(model)) begin
      fails++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd, pack(model));
    end
    tests++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
    end
  endtask

  task automatic idle_pulses();
    w1 = 0; b1 = 0; ca = 0; cb = 0; cp = 0; w0 = 0; wr = 0; wd = '0; ack = '0;
  endtask

  // Apply current stimulus over one edge, then check.
  task automatic step(input string tag);
    logic [NS-1:0] nx;
    nx = next_flags(model);
    @(posedge clk); #1;
    model = nx;
    check(tag);
    idle_pulses();
  endtask

  initial begin
    #(4 * 60000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a3c7));
    idle_pulses();
    pwm = 0; gie = 0; ien = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1; check("R1 in reset");
    w1 = 1; ca = 1; w0 = 1;  // events during reset must not stick
    @(posedge clk); #1; idle_pulses();
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1; check("R1 after release");

    // R2: each event to its bit
    w1 = 1; step("R2 t1 wrap bit7");
    ca = 1; step("R2 cmp A bit6");
    cb = 1; step("R2 cmp B bit5");
    cp = 1; step("R2 capture bit3");
    w0 = 1; step("R2 t0 wrap bit1");
    // R4: write zero keeps, write one clears
    wr = 1; wd = 8'h00; step("R4 write zero keeps");
    wr = 1; wd = 8'h80; step("R4 write one clears bit7");
    // R3: reserved bits
    wr = 1; wd = 8'h15; step("R3 reserved write");
    // R6: request gating
    ien = 5'b11111; step("R6 gie low");
    gie = 1; #1; check("R6 gie high same cycle");
    ien = 5'b00110; #1; check("R6 partial enable");
    ien = 5'b11111;
    // R5: acknowledge
    ack = 5'b00010; step("R5 ack cmp A");
    ack = 5'b10000; step("R5 ack t0 wrap");
    // R7: set vs clear
    cb = 1; wr = 1; wd = 8'h20; step("R7 set beats write clear");
    cp = 1; ack = 5'b01000; step("R7 set beats ack");
    // R8 / R9
    pwm = 1; w1 = 1; step("R8 pwm wrap ignored");
    b1 = 1; step("R8 pwm bottom sets");
    wr = 1; wd = 8'hFF; step("R4 clear all");
    pwm = 0; b1 = 1; step("R9 bottom ignored");
    w1 = 1; step("R9 wrap sets");

    for (int c = 0; c < RAND_CYCLES; c++) begin
      pwm = ($urandom % 8) == 0 ? ~pwm : pwm;
      gie = ($urandom % 4) != 0;
      ien = NS'($urandom);
      w1 = ($urandom % 4) == 0; b1 = ($urandom % 4) == 0;
      ca = ($urandom % 5) == 0; cb = ($urandom % 5) == 0;
      cp = ($urandom % 5) == 0; w0 = ($urandom % 4) == 0;
      wr = ($urandom % 3) == 0; wd = DW'($urandom);
      ack = NS'($urandom) & NS'($urandom);
      step("R7 random mix");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule